// File: doc/BRIEF.md
# Least-Recently-Used Translation Cache

This block is a small, fully associative cache that holds recent translations from virtual page numbers to page-table entries. It sits between the address-translation logic and a page-table walker. A requester presents a virtual page number, the access rights it needs and whether the access is a store. In the same cycle the block answers with a hit and the cached entry, or with a miss that sends the request to the walker. The walker's result is then written back through the fill port.

Replacement is exact least-recently-used. Every entry carries a small age, and the youngest entry has age zero. Each hit or fill makes the touched entry the youngest, and every entry that was younger than it ages by one step. A store that hits an entry whose dirty flag is clear marks that entry dirty, sets the D bit in the cached entry, and pulses an update so that the entry in memory can be given its D bit too. A single flush input, driven by an address-space fence or by a change of the page-table base, empties the whole cache.

Top module: `lru_tlb`

## Requirements
- R1: After reset every entry is invalid, every lookup misses, and `dupd_valid` is low.
- R2: A lookup hits in the same cycle when a valid entry holds the same VPN and the access is granted. `lk_pte` then shows that entry's PTE. On a miss `lk_pte` is zero.
- R3: A hit or a fill makes the touched entry the most recent. Entries that were more recent than it become one step older. When all slots are valid, the next fill evicts the entry that has gone longest without a touch.
- R4: A granted store hit (`lk_write`=1) returns the PTE with bit 7 (D) set and keeps bit 7 set in the cached copy. If the entry was not yet dirty, it also raises `dupd_valid` in that cycle, with the VPN and the PTE with D set. A later store hit to the same entry raises no update.
- R5: A fill writes into the lowest-numbered invalid slot while one exists, and otherwise replaces the least recent entry. The new entry is valid, most recent and not dirty.
- R6: A flush invalidates every entry and restores the initial recency order. Lookups after it miss.
- R7: `lk_acc` is {X,W,R} and is compared with PTE bits [3:1] = {X,W,R}. If no requested right is present, the lookup reports a miss and changes no state.
- R8: A flush takes priority. A fill in the same cycle is dropped, and a lookup in the same cycle reports a miss.
- R9: A fill whose VPN is already resident replaces that entry in place and clears its dirty flag, so no duplicate entry arises.
- R10: While `fill_valid` is high, a lookup in the same cycle reports a miss and has no effect on recency or on the dirty state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| flush | input | 1 | Invalidate all entries |
| lk_valid | input | 1 | Lookup request |
| lk_vpn | input | VPN_W | Lookup virtual page number |
| lk_acc | input | 3 | Requested rights {X,W,R} |
| lk_write | input | 1 | Lookup is a store |
| lk_hit | output | 1 | Lookup hit (combinational) |
| lk_pte | output | PTE_W | PTE returned on hit, zero otherwise |
| fill_valid | input | 1 | Insert a walker result |
| fill_vpn | input | VPN_W | VPN to insert |
| fill_pte | input | PTE_W | PTE to insert |
| dupd_valid | output | 1 | Dirty update of the in-memory PTE |
| dupd_vpn | output | VPN_W | VPN of the updated PTE |
| dupd_pte | output | PTE_W | PTE value with D set |

## Verification
The bench runs read hits and misses first. These show that both the VPN match and the permission gate work, because the same VPN hits with one access mask and misses with another. Repeated store hits show that the dirty update is raised only on the first store, and that a refill re-arms it. A full cache with one entry touched in between, followed by extra fills, shows true LRU order rather than insertion order. Cycles that combine flush, fill and lookup show the priority among the three.

// File: rtl/lru_tlb_pkg.sv
package lru_tlb_pkg;
  localparam int DIRTY_BIT = 7;
  localparam int RWX_LO    = 1;

  // any requested right present in the entry's {X,W,R} field
  function automatic logic rights_ok(input logic [2:0] rwx, input logic [2:0] need);
    return |(rwx & need);
  endfunction

  // recency step: touched entry becomes 0, younger ones grow by one
  function automatic int unsigned next_age(input int unsigned cur,
                                           input int unsigned pivot,
                                           input logic touched);
    if (touched) return 0;
    if (cur < pivot) return cur + 1;
    return cur;
  endfunction
endpackage

// File: rtl/tlb_match.sv
module tlb_match #(
  parameter int N     = 16,
  parameter int VPN_W = 20
) (
  input  logic [N-1:0]            valid,
  input  logic [N-1:0][VPN_W-1:0] tags,
  input  logic [VPN_W-1:0]        key,
  output logic [N-1:0]            match
);
  for (genvar i = 0; i < N; i++) begin : g_cmp
    assign match[i] = valid[i] && (tags[i] == key);
  end
endmodule

// File: rtl/tlb_victim.sv
module tlb_victim #(
  parameter int N  = 16,
  parameter int AW = $clog2(N)
) (
  input  logic [N-1:0]         valid,
  input  logic [N-1:0][AW-1:0] ages,
  input  logic [N-1:0]         resident,
  output logic [AW-1:0]        slot
);
  logic [AW-1:0] res_idx, free_idx, old_idx;
  logic          any_free;

  always_comb begin
    res_idx  = '0;
    free_idx = '0;
    old_idx  = '0;
    any_free = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (resident[i]) res_idx = AW'(i);
      if (ages[i] == AW'(N - 1)) old_idx = AW'(i);
    end
    for (int i = N - 1; i >= 0; i--) begin
      if (!valid[i]) begin
        free_idx = AW'(i);
        any_free = 1'b1;
      end
    end
    if (|resident)     slot = res_idx;
    else if (any_free) slot = free_idx;
    else               slot = old_idx;
  end
endmodule

// File: rtl/tlb_age.sv
module tlb_age
  import lru_tlb_pkg::*;
#(
  parameter int N  = 16,
  parameter int AW = $clog2(N)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 flush,
  input  logic                 touch,
  input  logic [AW-1:0]        touch_idx,
  output logic [N-1:0][AW-1:0] age_q
);
  logic [AW-1:0] pivot;
  logic [N-1:0]  youngest;

  assign pivot = age_q[touch_idx];

  for (genvar i = 0; i < N; i++) begin : g_mru
    assign youngest[i] = (age_q[i] == '0);
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      for (int i = 0; i < N; i++) age_q[i] <= AW'(i);
    end else if (touch) begin
      for (int i = 0; i < N; i++)
        age_q[i] <= AW'(next_age(int'(age_q[i]), int'(pivot), touch_idx == AW'(i)));
    end
  end

  // ages remain a permutation: exactly one youngest entry
  p_one_mru_r3: assert property (@(posedge clk) disable iff (!rst_n)
    $countones(youngest) == 1);
  p_touch_mru_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (touch && !flush) |=> youngest[$past(touch_idx)]);
endmodule

// File: rtl/lru_tlb.sv
module lru_tlb
  import lru_tlb_pkg::*;
#(
  parameter int N     = 16,
  parameter int VPN_W = 20,
  parameter int PTE_W = 32
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             flush,
  input  logic             lk_valid,
  input  logic [VPN_W-1:0] lk_vpn,
  input  logic [2:0]       lk_acc,
  input  logic             lk_write,
  output logic             lk_hit,
  output logic [PTE_W-1:0] lk_pte,
  input  logic             fill_valid,
  input  logic [VPN_W-1:0] fill_vpn,
  input  logic [PTE_W-1:0] fill_pte,
  output logic             dupd_valid,
  output logic [VPN_W-1:0] dupd_vpn,
  output logic [PTE_W-1:0] dupd_pte
);
  localparam int AW = $clog2(N);
  localparam logic [PTE_W-1:0] D_MASK = PTE_W'(1) << DIRTY_BIT;

  logic [N-1:0]            valid_q, dirty_q;
  logic [N-1:0][VPN_W-1:0] vpn_q;
  logic [N-1:0][PTE_W-1:0] pte_q;
  logic [N-1:0][AW-1:0]    age_q;

  logic [N-1:0]  lk_match, fill_match;
  logic [AW-1:0] hit_idx, fill_idx, touch_idx;
  logic [PTE_W-1:0] hit_pte;
  logic hit_dirty, lk_active, granted, fill_do, touch;

  tlb_match #(.N(N), .VPN_W(VPN_W)) u_lk_cam (
    .valid(valid_q), .tags(vpn_q), .key(lk_vpn), .match(lk_match));
  tlb_match #(.N(N), .VPN_W(VPN_W)) u_fill_cam (
    .valid(valid_q), .tags(vpn_q), .key(fill_vpn), .match(fill_match));

  tlb_victim #(.N(N), .AW(AW)) u_victim (
    .valid(valid_q), .ages(age_q), .resident(fill_match), .slot(fill_idx));

  always_comb begin
    hit_idx   = '0;
    hit_pte   = '0;
    hit_dirty = 1'b0;
    for (int i = 0; i < N; i++) begin
      if (lk_match[i]) begin
        hit_idx   = AW'(i);
        hit_pte   = hit_pte | pte_q[i];
        hit_dirty = hit_dirty | dirty_q[i];
      end
    end
  end

  assign lk_active  = lk_valid && !flush && !fill_valid;
  assign granted    = rights_ok(hit_pte[RWX_LO+2:RWX_LO], lk_acc);
  assign lk_hit     = lk_active && (|lk_match) && granted;
  assign lk_pte     = !lk_hit ? '0 : (lk_write ? (hit_pte | D_MASK) : hit_pte);
  assign dupd_valid = lk_hit && lk_write && !hit_dirty;
  assign dupd_vpn   = lk_vpn;
  assign dupd_pte   = hit_pte | D_MASK;

  assign fill_do   = fill_valid && !flush;
  assign touch     = fill_do || lk_hit;
  assign touch_idx = fill_do ? fill_idx : hit_idx;

  tlb_age #(.N(N), .AW(AW)) u_age (
    .clk(clk), .rst_n(rst_n), .flush(flush), .touch(touch),
    .touch_idx(touch_idx), .age_q(age_q));

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      valid_q <= '0;
      dirty_q <= '0;
    end else if (fill_do) begin
      valid_q[fill_idx] <= 1'b1;
      dirty_q[fill_idx] <= 1'b0;
    end else if (lk_hit && lk_write) begin
      dirty_q[hit_idx] <= 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (fill_do) begin
      vpn_q[fill_idx] <= fill_vpn;
      pte_q[fill_idx] <= fill_pte;
    end else if (lk_hit && lk_write) begin
      pte_q[hit_idx] <= hit_pte | D_MASK;
    end
  end

  p_hit_onehot_r2: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0(lk_match));
  p_dirty_after_store_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (dupd_valid && !flush) |=> dirty_q[$past(hit_idx)]);
  p_fill_fresh_r5: assert property (@(posedge clk) disable iff (!rst_n)
    fill_do |=> (valid_q[$past(fill_idx)] && !dirty_q[$past(fill_idx)]
                 && age_q[$past(fill_idx)] == '0));
  p_flush_empty_r6: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (valid_q == '0));
  p_flush_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    flush |-> (!lk_hit && !dupd_valid));
  p_fill_blocks_r10: assert property (@(posedge clk) disable iff (!rst_n)
    fill_valid |-> !lk_hit);
endmodule

// File: tb/lru_tlb_test.sv
module lru_tlb_test;
  localparam int PER   = 10;
  localparam int N     = 16;
  localparam int VPN_W = 20;
  localparam int PTE_W = 32;

  logic clk = 0, rst_n = 0, flush = 0;
  logic lk_valid = 0, lk_write = 0, fill_valid = 0;
  logic [VPN_W-1:0] lk_vpn = '0, fill_vpn = '0;
  logic [2:0] lk_acc = '0;
  logic [PTE_W-1:0] fill_pte = '0;
  logic lk_hit, dupd_valid;
  logic [PTE_W-1:0] lk_pte, dupd_pte;
  logic [VPN_W-1:0] dupd_vpn;

  int checks = 0, errors = 0;
  bit done = 0;

  lru_tlb #(.N(N), .VPN_W(VPN_W), .PTE_W(PTE_W)) uut (.*);

  always #(PER/2) clk = ~clk;

  // reference model: recency kept as an ordered list, front = newest
  bit              m_val[N];
  bit              m_dirty[N];
  logic [VPN_W-1:0] m_vpn[N];
  logic [PTE_W-1:0] m_pte[N];
  int              order[$];

  // scoreboard queues
  string            q_tag[$];
  bit               q_hit[$], q_up[$];
  logic [PTE_W-1:0] q_pte[$], q_upte[$];
  logic [VPN_W-1:0] q_uvpn[$];

  function automatic void m_reset();
    order.delete();
    for (int i = 0; i < N; i++) begin
      m_val[i] = 0; m_dirty[i] = 0; order.push_back(i);
    end
  endfunction

  function automatic void m_touch(int idx);
    for (int k = 0; k < order.size(); k++)
      if (order[k] == idx) begin order.delete(k); break; end
    order.push_front(idx);
  endfunction

  function automatic int m_find(logic [VPN_W-1:0] v);
    for (int i = 0; i < N; i++) if (m_val[i] && m_vpn[i] == v) return i;
    return -1;
  endfunction

  task automatic check(string tag, string what, logic [PTE_W-1:0] act, logic [PTE_W-1:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s: actual=%h expected=%h", tag, what, act, exp);
    end
  endtask

  // one cycle of stimulus with model update
  task automatic cyc(bit fl, bit fv, logic [VPN_W-1:0] fvpn, logic [PTE_W-1:0] fpte,
                     bit lv, logic [VPN_W-1:0] lvpn, logic [2:0] acc, bit wr, string tag);
    int idx;
    bit hit;
    @(negedge clk);
    flush = fl; fill_valid = fv; fill_vpn = fvpn; fill_pte = fpte;
    lk_valid = lv; lk_vpn = lvpn; lk_acc = acc; lk_write = wr;
    idx = m_find(lvpn);
    hit = lv && !fl && !fv && idx >= 0 && (|(m_pte[idx][3:1] & acc));
    if (lv) begin
      q_tag.push_back(tag);
      q_hit.push_back(hit);
      q_pte.push_back(!hit ? '0 : (wr ? (m_pte[idx] | 32'h80) : m_pte[idx]));
      q_up.push_back(hit && wr && !m_dirty[idx]);
      q_upte.push_back(hit ? (m_pte[idx] | 32'h80) : '0);
      q_uvpn.push_back(lvpn);
    end
    if (fl) m_reset();
    else if (fv) begin
      int s;
      s = m_find(fvpn);
      if (s < 0) for (int i = N - 1; i >= 0; i--) if (!m_val[i]) s = i;
      if (s < 0) s = order[order.size() - 1];
      m_val[s] = 1; m_dirty[s] = 0; m_vpn[s] = fvpn; m_pte[s] = fpte;
      m_touch(s);
    end else if (hit) begin
      if (wr) begin m_dirty[idx] = 1; m_pte[idx] = m_pte[idx] | 32'h80; end
      m_touch(idx);
    end
    @(posedge clk); #1;
    flush = 0; fill_valid = 0; lk_valid = 0; lk_write = 0;
  endtask

  task automatic look(logic [VPN_W-1:0] v, logic [2:0] acc, bit wr, string tag);
    cyc(0, 0, '0, '0, 1, v, acc, wr, tag);
  endtask
  task automatic fill(logic [VPN_W-1:0] v, logic [PTE_W-1:0] p);
    cyc(0, 1, v, p, 0, '0, '0, 0, "");
  endtask

  // monitor: compare each lookup result in its own cycle
  initial forever begin
    @(negedge clk); #(PER/4);
    if (q_tag.size() > 0) begin
      string t;
      bit up;
      t = q_tag.pop_front();
      check(t, "hit", PTE_W'(lk_hit), PTE_W'(q_hit.pop_front()));
      check(t, "pte", lk_pte, q_pte.pop_front());
      up = q_up.pop_front();
      check(t, "dupd_valid", PTE_W'(dupd_valid), PTE_W'(up));
      if (up) begin
        check(t, "dupd_pte", dupd_pte, q_upte.pop_front());
        check(t, "dupd_vpn", PTE_W'(dupd_vpn), PTE_W'(q_uvpn.pop_front()));
      end else begin
        void'(q_upte.pop_front()); void'(q_uvpn.pop_front());
      end
    end
  end

  initial begin
    #(PER * 20000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog: actual=timeout expected=finish");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    m_reset();
    repeat (3) @(posedge clk);
    #1 rst_n = 1;
    @(negedge clk);
    check("R1", "idle hit", PTE_W'(lk_hit), '0);
    check("R1", "idle dupd", PTE_W'(dupd_valid), '0);
    look(20'h12345, 3'b111, 0, "R1");

    fill(20'h00010, (32'h00ABC << 10) | 32'h3);   // V,R
    fill(20'h00020, (32'h00DEF << 10) | 32'h7);   // V,R,W
    fill(20'h00030, (32'h00123 << 10) | 32'h9);   // V,X
    look(20'h00010, 3'b001, 0, "R2");
    look(20'h00030, 3'b001, 0, "R7");
    look(20'h00030, 3'b100, 0, "R7");
    look(20'h00010, 3'b010, 1, "R7");
    look(20'h00010, 3'b000, 0, "R7");
    look(20'h00020, 3'b010, 1, "R4");
    look(20'h00020, 3'b010, 1, "R4");
    look(20'h00020, 3'b001, 0, "R4");
    fill(20'h00020, (32'h00777 << 10) | 32'h7);
    look(20'h00020, 3'b001, 0, "R9");
    look(20'h00020, 3'b010, 1, "R9");

    cyc(1, 0, '0, '0, 0, '0, '0, 0, "");
    look(20'h00010, 3'b001, 0, "R6");

    for (int i = 0; i < N; i++) fill(20'h100 + 20'(i), (32'(i) << 10) | 32'h3);
    look(20'h100, 3'b001, 0, "R3");
    fill(20'h200, 32'h3);
    look(20'h101, 3'b001, 0, "R5");
    look(20'h100, 3'b001, 0, "R3");
    look(20'h200, 3'b001, 0, "R5");
    fill(20'h201, 32'h3);
    look(20'h102, 3'b001, 0, "R3");
    look(20'h103, 3'b001, 0, "R3");

    cyc(1, 1, 20'h300, 32'h3, 0, '0, '0, 0, "");
    look(20'h300, 3'b001, 0, "R8");
    fill(20'h301, 32'h7);
    cyc(0, 1, 20'h302, 32'h3, 1, 20'h301, 3'b010, 1, "R10");
    look(20'h301, 3'b010, 1, "R10");
    cyc(1, 0, '0, '0, 1, 20'h301, 3'b001, 0, "R8");
    look(20'h301, 3'b001, 0, "R6");

    repeat (2) @(negedge clk);
    done = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule